// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Device Model

This block is a synthesizable stand-in for a small word-organized serial EEPROM. It can be placed on a chip or in a bench wherever a controller expects to talk to such a memory. It holds 2^ADDR_W words of DATA_W bits, which by default is 64 words of 16 bits; setting ADDR_W to 8 gives 256 words. Storage is an internal register array. Every word resets to the erased value, all ones.

The host drives three signals. A chip select frames each command. A serial clock marks the bit boundaries, and a serial data input carries the bits, which are taken on each rising serial clock edge. The block oversamples these signals with its own system clock. A command has four parts, sent in this order:
- a start bit of 1;
- two opcode bits;
- ADDR_W address bits;
- for writes, DATA_W data bits.

Reads return a zero, then the word MSB first. Every programming command is gated by a write-enable latch. After a programming command has run, the next time chip select goes high the data output reports busy (0) or ready (1). The programming time is a fixed number of system clocks.

The block can only drive the data output when it is reading or reporting status. At all other times its output enable is low and the data line rests at 1.

Top module: `mwEeprom`

## Requirements
- R1: After reset, the write-enable latch is clear, every word reads 16'hFFFF, doOe is 0 and doOut is 1.
- R2: While cs is high and the block is idle, 0 bits are skipped until a 1 start bit arrives. The next two bits are the opcode, then ADDR_W address bits MSB first. No other command can begin until cs has been low.
- R3: Opcode 2'b10 reads. On the rising sk edge that carries the last address bit, doOe goes high and doOut gives 0. Each later rising edge launches the next word bit, starting with bit 15 and ending with bit 0. Edges after bit 0 give 0.
- R4: Opcode 2'b01 writes. It takes DATA_W data bits MSB first after the address and, when enabled, stores them at the address.
- R5: Opcode 2'b11 erases. When enabled, the addressed word becomes 16'hFFFF at the end of the address.
- R6: With opcode 2'b00, the two top address bits choose the command and the remaining address bits are ignored:
  - 2'b11 sets the write-enable latch;
  - 2'b00 clears it;
  - 2'b10 sets every word to 16'hFFFF;
  - 2'b01 takes DATA_W data bits and writes them to every word.
- R7: Write, erase, erase-all and write-all have no effect, and leave no status pending, while the write-enable latch is clear.
- R8: After a programming command has executed, chip select going high again with no start bit gives doOe=1. doOut is then 0 for BUSY_CYCLES system clocks from execution, and 1 after that.
- R9: While the busy interval runs, start bits are ignored and the status output stays in place.
- R10: cs low returns the block to idle from any state. A command cut short has no effect, and doOe is 0 on the clock after cs is sampled low.
- R11: Whenever the block is neither reading nor reporting status, doOe is 0 and doOut is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial lines |
| rst_n | input | 1 | Active-low synchronous reset |
| sk | input | 1 | Serial bit clock from the host; bits are taken on its rising edge |
| cs | input | 1 | Chip select; high frames a command |
| di | input | 1 | Serial data from the host |
| doOut | output | 1 | Serial data to the host: read bits or ready/busy status |
| doOe | output | 1 | Output enable for doOut |

## Verification
Most internal faults reach the ports within one command.
- A wrong bit counter or opcode decode shifts the response by whole sk periods. It can also make the dummy zero disappear or turn a read into a silent cycle, so the read that follows already shows the fault.
- A wrong write-enable latch or word-select decode leaves a bad word in the array. That word only shows up on a later read of that address, or of any address after a write-all or erase-all. The bench therefore reads back after every programming command in its directed part.
- A stuck busy counter shows in the status bit, which is sampled both early in the interval and after it.

// File: rtl/mwEepromPkg.sv
package mwEepromPkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPC,
    ST_ADDR,
    ST_DATA,
    ST_READ,
    ST_DONE
  } mwState_t;

  // strobes from control to datapath, valid for one system clock
  typedef struct packed {
    logic shiftCmd;   // take di into the opcode/address register
    logic shiftData;  // take di into the data register
    logic loadRead;   // load the read word behind a dummy zero
    logic shiftOut;   // advance the read shifter
    logic wrOne;      // program the selected word
    logic wrAll;      // program every word
    logic useOnes;    // program with all ones instead of the data register
  } mwStrobe_t;

  localparam logic [1:0] OP_EXT   = 2'b00;
  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] OP_READ  = 2'b10;
  localparam logic [1:0] OP_ERASE = 2'b11;

  localparam logic [1:0] SEL_WDS  = 2'b00;
  localparam logic [1:0] SEL_WRAL = 2'b01;
  localparam logic [1:0] SEL_ERAL = 2'b10;
  localparam logic [1:0] SEL_WEN  = 2'b11;

endpackage

// File: rtl/mwEepromData.sv
module mwEepromData
  import mwEepromPkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       di,
  input  mwStrobe_t  strb,
  output logic [1:0] opNext,
  output logic [1:0] selNext,
  output logic [1:0] opHeld,
  output logic       serialBit
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam int CMD_W = ADDR_W + 2;

  logic [CMD_W-1:0]  cmdSr;
  logic [CMD_W-1:0]  cmdNext;
  logic [DATA_W-1:0] dataSr;
  logic [DATA_W-1:0] dataNext;
  logic [DATA_W:0]   outSr;
  logic [ADDR_W-1:0] selAddr;
  logic [DATA_W-1:0] wrData;
  logic [DEPTH-1:0]  wordWe;
  logic [DATA_W-1:0] mem [DEPTH];

  assign cmdNext  = {cmdSr[CMD_W-2:0], di};
  assign dataNext = {dataSr[DATA_W-2:0], di};
  assign opNext   = cmdNext[CMD_W-1 -: 2];
  assign selNext  = cmdNext[ADDR_W-1 -: 2];
  assign opHeld   = cmdSr[CMD_W-1 -: 2];

  // the address edge uses the bit arriving now, later phases use the held one
  assign selAddr  = strb.shiftCmd ? cmdNext[ADDR_W-1:0] : cmdSr[ADDR_W-1:0];
  assign wrData   = strb.useOnes ? {DATA_W{1'b1}} : dataNext;

  generate
    for (genvar w = 0; w < DEPTH; w++) begin : g_we
      assign wordWe[w] = strb.wrAll | (strb.wrOne && (selAddr == ADDR_W'(w)));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmdSr  <= '0;
      dataSr <= '0;
    end else begin
      if (strb.shiftCmd)  cmdSr  <= cmdNext;
      if (strb.shiftData) dataSr <= dataNext;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int w = 0; w < DEPTH; w++) mem[w] <= '1;
    end else begin
      for (int w = 0; w < DEPTH; w++) begin
        if (wordWe[w]) mem[w] <= wrData;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outSr <= '0;
    end else if (strb.loadRead) begin
      outSr <= {1'b0, mem[selAddr]};
    end else if (strb.shiftOut) begin
      outSr <= {outSr[DATA_W-1:0], 1'b0};
    end
  end

  assign serialBit = outSr[DATA_W];

endmodule

// File: rtl/mwEepromCtrl.sv
module mwEepromCtrl
  import mwEepromPkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 16,
  parameter int BUSY_CYCLES = 40,
  localparam int BUSY_W     = $clog2(BUSY_CYCLES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sk,
  input  logic              cs,
  input  logic              di,
  input  logic [1:0]        opNext,
  input  logic [1:0]        selNext,
  input  logic [1:0]        opHeld,
  input  logic              serialBit,
  output mwStrobe_t         strb,
  output mwState_t          state,
  output logic              wenQ,
  output logic              busy,
  output logic [BUSY_W-1:0] busyCnt,
  output logic              startProg,
  output logic              doOut,
  output logic              doOe
);

  localparam int CNT_MAX = (DATA_W > ADDR_W) ? DATA_W : ADDR_W;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic             skQ;
  logic             skRise;
  mwState_t         stateNext;
  logic [CNT_W-1:0] bitCnt;
  logic [CNT_W-1:0] bitCntNext;
  logic             wenNext;
  logic             statusPend;
  logic             pendNext;
  logic             lastAddr;
  logic             lastData;
  logic             statusOn;
  logic             readOn;

  assign skRise   = sk & ~skQ;
  assign lastAddr = (bitCnt == CNT_W'(ADDR_W - 1));
  assign lastData = (bitCnt == CNT_W'(DATA_W - 1));
  assign busy     = (busyCnt != '0);

  always_comb begin
    stateNext  = state;
    bitCntNext = bitCnt;
    wenNext    = wenQ;
    pendNext   = statusPend;
    strb       = '0;
    startProg  = 1'b0;
    if (!cs) begin
      stateNext = ST_IDLE;
    end else if (skRise) begin
      unique case (state)
        ST_IDLE: begin
          if (di && !busy) begin
            stateNext  = ST_OPC;
            bitCntNext = '0;
            pendNext   = 1'b0;
          end
        end
        ST_OPC: begin
          strb.shiftCmd = 1'b1;
          if (bitCnt == CNT_W'(1)) begin
            stateNext  = ST_ADDR;
            bitCntNext = '0;
          end else begin
            bitCntNext = bitCnt + 1'b1;
          end
        end
        ST_ADDR: begin
          strb.shiftCmd = 1'b1;
          if (lastAddr) begin
            bitCntNext = '0;
            stateNext  = ST_DONE;
            unique case (opNext)
              OP_READ: begin
                strb.loadRead = 1'b1;
                stateNext     = ST_READ;
              end
              OP_WRITE: stateNext = ST_DATA;
              OP_ERASE: begin
                if (wenQ) begin
                  strb.wrOne    = 1'b1;
                  strb.useOnes  = 1'b1;
                  startProg     = 1'b1;
                end
              end
              default: begin
                unique case (selNext)
                  SEL_WEN:  wenNext = 1'b1;
                  SEL_WDS:  wenNext = 1'b0;
                  SEL_ERAL: begin
                    if (wenQ) begin
                      strb.wrAll   = 1'b1;
                      strb.useOnes = 1'b1;
                      startProg    = 1'b1;
                    end
                  end
                  default:  stateNext = ST_DATA;
                endcase
              end
            endcase
          end else begin
            bitCntNext = bitCnt + 1'b1;
          end
        end
        ST_DATA: begin
          strb.shiftData = 1'b1;
          if (lastData) begin
            stateNext = ST_DONE;
            if (wenQ) begin
              startProg = 1'b1;
              if (opHeld == OP_EXT) strb.wrAll = 1'b1;
              else                  strb.wrOne = 1'b1;
            end
          end else begin
            bitCntNext = bitCnt + 1'b1;
          end
        end
        ST_READ: strb.shiftOut = 1'b1;
        default: ;
      endcase
    end
    if (startProg) pendNext = 1'b1;
  end

  assign statusOn = cs && (state == ST_IDLE) && statusPend;
  assign readOn   = cs && (state == ST_READ);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      skQ        <= 1'b0;
      state      <= ST_IDLE;
      bitCnt     <= '0;
      wenQ       <= 1'b0;
      statusPend <= 1'b0;
      busyCnt    <= '0;
      doOut      <= 1'b1;
      doOe       <= 1'b0;
    end else begin
      skQ        <= sk;
      state      <= stateNext;
      bitCnt     <= bitCntNext;
      wenQ       <= wenNext;
      statusPend <= pendNext;
      if (startProg)  busyCnt <= BUSY_W'(BUSY_CYCLES);
      else if (busy)  busyCnt <= busyCnt - 1'b1;
      doOe  <= statusOn | readOn;
      doOut <= readOn ? serialBit : (statusOn ? ~busy : 1'b1);
    end
  end

endmodule

// File: rtl/mwEeprom.sv
module mwEeprom
  import mwEepromPkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 16,
  parameter int BUSY_CYCLES = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sk,
  input  logic cs,
  input  logic di,
  output logic doOut,
  output logic doOe
);

  localparam int BUSY_W = $clog2(BUSY_CYCLES + 1);

  mwStrobe_t         strb;
  mwState_t          state;
  logic [1:0]        opNext;
  logic [1:0]        selNext;
  logic [1:0]        opHeld;
  logic              serialBit;
  logic              wenQ;
  logic              busy;
  logic [BUSY_W-1:0] busyCnt;
  logic              startProg;

  mwEepromCtrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BUSY_CYCLES(BUSY_CYCLES)
  ) ctrl_i (
    .clk(clk), .rst_n(rst_n), .sk(sk), .cs(cs), .di(di),
    .opNext(opNext), .selNext(selNext), .opHeld(opHeld), .serialBit(serialBit),
    .strb(strb), .state(state), .wenQ(wenQ), .busy(busy), .busyCnt(busyCnt),
    .startProg(startProg), .doOut(doOut), .doOe(doOe)
  );

  mwEepromData #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) data_i (
    .clk(clk), .rst_n(rst_n), .di(di), .strb(strb),
    .opNext(opNext), .selNext(selNext), .opHeld(opHeld), .serialBit(serialBit)
  );

endmodule

// File: rtl/mwEepromChk.sv
module mwEepromChk
  import mwEepromPkg::*;
#(
  parameter int BUSY_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs,
  input logic              doOe,
  input mwState_t          state,
  input mwStrobe_t         strb,
  input logic              wenQ,
  input logic              busy,
  input logic [BUSY_W-1:0] busyCnt,
  input logic              startProg
);

  // R10: deselect removes the output drive on the next clock
  p_deselect_oe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !cs |=> !doOe);

  // R7: the array is only programmed with the enable latch set
  p_prog_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.wrOne || strb.wrAll) |-> wenQ);

  // R9: no command starts while programming time runs
  p_busy_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && state == ST_IDLE) |=> (state == ST_IDLE));

  // R8: busy interval counts down one per clock
  p_busy_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !startProg) |=> (busyCnt == $past(busyCnt) - 1'b1));

  // R3: a selected read drives the line
  p_read_drive_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && state == ST_READ) |=> doOe);

endmodule

bind mwEeprom mwEepromChk #(.BUSY_W(BUSY_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cs(cs), .doOe(doOe), .state(state), .strb(strb),
  .wenQ(wenQ), .busy(busy), .busyCnt(busyCnt), .startProg(startProg)
);

// File: tb/mwEeprom_tb.sv
module mwEeprom_tb_top;

  localparam int ADDR_W = 6;
  localparam int DATA_W = 16;
  localparam int BUSY   = 200;
  localparam int DEPTH  = 1 << ADDR_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sk = 1'b0;
  logic cs = 1'b0;
  logic di = 1'b0;
  logic doOut, doOe;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  logic [DATA_W-1:0] refMem [DEPTH];
  logic refWen;

  always #10 clk = ~clk;

  mwEeprom #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BUSY_CYCLES(BUSY)) dut_i (
    .clk(clk), .rst_n(rst_n), .sk(sk), .cs(cs), .di(di),
    .doOut(doOut), .doOe(doOe)
  );

  function automatic logic [DATA_W-1:0] expWord(input int a);
    return refMem[a];
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic sendBit(input logic b, output logic q);
    @(negedge clk) di = b; sk = 1'b1;
    repeat (3) @(negedge clk);
    q = doOut;
    sk = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic csHigh();
    @(negedge clk) cs = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic csLow();
    @(negedge clk) cs = 1'b0; sk = 1'b0; di = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic sendHead(input logic [1:0] op, input logic [ADDR_W-1:0] a, output logic q);
    sendBit(1'b1, q);
    sendBit(op[1], q);
    sendBit(op[0], q);
    for (int i = ADDR_W - 1; i >= 0; i--) sendBit(a[i], q);
  endtask

  task automatic sendData(input logic [DATA_W-1:0] d);
    logic q;
    for (int i = DATA_W - 1; i >= 0; i--) sendBit(d[i], q);
  endtask

  task automatic statusCheck(input bit prog, input string req);
    csHigh();
    if (prog) begin
      chk({req, "/R8 busy oe"}, doOe, 1'b1);
      chk({req, "/R8 busy level"}, doOut, 1'b0);
      repeat (BUSY + 5) @(negedge clk);
      chk({req, "/R8 ready level"}, doOut, 1'b1);
    end else begin
      chk({req, "/R7 no status"}, doOe, 1'b0);
    end
    csLow();
  endtask

  task automatic doRead(input int a, input string req);
    logic q;
    logic [DATA_W-1:0] w;
    csHigh();
    sendHead(2'b10, ADDR_W'(a), q);
    chk({req, "/R3 dummy"}, q, 1'b0);
    chk({req, "/R3 oe"}, doOe, 1'b1);
    w = '0;
    for (int i = 0; i < DATA_W; i++) begin
      sendBit(1'b0, q);
      w = {w[DATA_W-2:0], q};
    end
    chk(req, w, expWord(a));
    sendBit(1'b0, q);
    chk("R3 past last bit", q, 1'b0);
    csLow();
  endtask

  task automatic doWrite(input int a, input logic [DATA_W-1:0] d, input string req);
    logic q;
    bit prog;
    csHigh();
    sendHead(2'b01, ADDR_W'(a), q);
    sendData(d);
    csLow();
    prog = refWen;
    if (prog) refMem[a] = d;
    statusCheck(prog, req);
  endtask

  task automatic doErase(input int a);
    logic q;
    bit prog;
    csHigh();
    sendHead(2'b11, ADDR_W'(a), q);
    csLow();
    prog = refWen;
    if (prog) refMem[a] = '1;
    statusCheck(prog, "R5 erase");
  endtask

  task automatic doExt(input logic [1:0] sel, input logic [DATA_W-1:0] d);
    logic q;
    bit prog;
    logic [ADDR_W-1:0] a;
    a = {sel, ADDR_W'($urandom) & {2'b00, {(ADDR_W-2){1'b1}}}};
    a[ADDR_W-1 -: 2] = sel;
    csHigh();
    sendHead(2'b00, a, q);
    if (sel == 2'b01) sendData(d);
    repeat (2) @(negedge clk);
    chk("R11 idle after command oe", doOe, 1'b0);
    chk("R11 idle after command level", doOut, 1'b1);
    csLow();
    prog = 0;
    unique case (sel)
      2'b11: refWen = 1'b1;
      2'b00: refWen = 1'b0;
      2'b10: begin prog = refWen; if (prog) for (int i = 0; i < DEPTH; i++) refMem[i] = '1; end
      default: begin prog = refWen; if (prog) for (int i = 0; i < DEPTH; i++) refMem[i] = d; end
    endcase
    if (sel == 2'b10 || sel == 2'b01) statusCheck(prog, "R6 bulk");
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic q;
    void'($urandom(32'd20240611));
    for (int i = 0; i < DEPTH; i++) refMem[i] = '1;
    refWen = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 reset oe", doOe, 1'b0);
    chk("R11 reset level", doOut, 1'b1);

    doRead(5, "R1 erased after reset");
    doRead(63, "R1 erased after reset top");
    doWrite(5, 16'h1234, "R7 write before enable");
    doRead(5, "R7 word unchanged");

    doExt(2'b11, '0);  // R6 enable
    // R2: leading zeros before the start bit are skipped
    csHigh();
    sendBit(1'b0, q); sendBit(1'b0, q); sendBit(1'b0, q);
    chk("R2 zeros ignored", doOe, 1'b0);
    sendHead(2'b01, ADDR_W'(5), q);
    sendData(16'h1234);
    csLow();
    refMem[5] = 16'h1234;
    statusCheck(1, "R4 write");
    doRead(5, "R4/R2 readback");

    doWrite(63, 16'hA5C3, "R4 write top");
    doWrite(0, 16'h0001, "R4 write bottom");
    doRead(63, "R4 readback top");
    doRead(0, "R4 readback bottom");

    doErase(5);
    doRead(5, "R5 erased word");

    // R9: start bits during busy are ignored, status stays
    csHigh();
    sendHead(2'b01, ADDR_W'(10), q);
    sendData(16'hBEEF);
    csLow();
    refMem[10] = 16'hBEEF;
    csHigh();
    sendBit(1'b1, q); sendBit(1'b1, q); sendBit(1'b0, q);
    chk("R9 status oe kept", doOe, 1'b1);
    chk("R9 status busy kept", q, 1'b0);
    csLow();
    statusCheck(1, "R9 still pending");
    doRead(10, "R9 readback");

    // R10: abort a write in its data phase
    csHigh();
    sendHead(2'b01, ADDR_W'(20), q);
    for (int i = 0; i < 8; i++) sendBit(1'b0, q);
    @(negedge clk) cs = 1'b0;
    repeat (2) @(negedge clk);
    chk("R10 oe after deselect", doOe, 1'b0);
    csLow();
    statusCheck(0, "R10 aborted");
    doRead(20, "R10 word unchanged");

    doExt(2'b01, 16'h5A5A);
    doRead(0, "R6 write-all low");
    doRead(37, "R6 write-all mid");
    doExt(2'b10, '0);
    doRead(63, "R6 erase-all");
    doWrite(7, 16'h00FF, "R4 write after erase-all");
    doExt(2'b00, '0);
    doWrite(7, 16'h1111, "R7 write after disable");
    doErase(7);
    doExt(2'b10, '0);
    doRead(7, "R7 disabled writes");
    doExt(2'b11, '0);

    for (int n = 0; n < 120; n++) begin
      int r;
      int a;
      logic [DATA_W-1:0] d;
      r = $urandom_range(0, 99);
      a = $urandom_range(0, DEPTH - 1);
      d = DATA_W'($urandom);
      if (r < 40)      doRead(a, "R3 random read");
      else if (r < 68) doWrite(a, d, "R4 random write");
      else if (r < 78) doErase(a);
      else if (r < 88) doExt(2'b11, '0);
      else if (r < 93) doExt(2'b00, '0);
      else if (r < 97) doExt(2'b01, d);
      else             doExt(2'b10, '0);
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule